// File: doc/BRIEF.md
# Eight-Pin GPIO Bank with Address-Masked Access and Pin Interrupts

This block is one bank of general-purpose I/O with eight pins behind a byte-wide register bus. It holds an output value and a direction for every pin. It samples the pin inputs through a two-stage synchronizer. It can hand any pin to an alternate function, which then supplies that pin's output value and output enable. For the output-value and direction registers, bits 9 down to 2 of the byte address act as a per-pin write and read mask. Software can therefore change one pin, or any set of pins, with a single write and no read-modify-write.

Every pin can raise an interrupt. Each pin chooses level or edge detection, the active level or edge, and, in edge mode, triggering on both edges. A detected edge is latched until software clears it. A level condition follows the synchronized pin with no latch. The masked status is the raw status ANDed with a per-pin enable, and the single interrupt output is the OR of the masked bits.

Reads are combinational. `busRdData` is valid in the same cycle that `busRdEn` is high, and it is zero when `busRdEn` is low. Address bits 1:0 are ignored.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every register is zero. All pins are inputs (`pinOe` = 0), `pinOut` = 0 and `irqOut` = 0.
- R2: A write with address bits 11:10 = 00 updates only those output-value bits whose mask bit (address bit n+2 for pin n) is set. All other output bits keep their value.
- R3: A read with address bits 11:10 = 00 returns the synchronized pin levels in the masked positions and zero elsewhere. A pin change shows up after two rising clock edges.
- R4: Address bits 11:10 = 10 give masked access to the direction register in the same way. A direction bit of 1 drives `pinOe` high for that pin. A read returns direction AND mask.
- R5: The alternate-select register sits at 0x420. When a bit is 1, that pin takes `pinOut` and `pinOe` from `altOut` and `altOe`. When the bit is 0, the pin takes them from the output-value and direction registers.
- R6: The mode register at 0x404 selects level detection with a 1 and edge detection with a 0. In level mode, the raw status bit is 1 while the synchronized pin equals the polarity bit. The polarity register is at 0x40C.
- R7: In edge mode without both-edge select, a polarity bit of 1 latches the raw status on a rising edge and a polarity bit of 0 latches it on a falling edge. The latched bit stays set after the pin returns to its former level.
- R8: When a bit of the both-edge register at 0x408 is set and the pin is in edge mode, either transition latches the status and the polarity bit is ignored.
- R9: The enable register is at 0x410. The raw status reads at 0x414. The masked status at 0x418 reads as raw AND enable. `irqOut` is 1 exactly when the masked status is nonzero.
- R10: Writing 1s to 0x41C clears the matching latched edge bits. The write has no effect on level-mode bits. An edge that arrives in the same cycle as a clear stays latched.
- R11: The mode, both-edge, polarity, enable and alternate-select registers read back as written. The raw and masked status registers ignore writes. The clear register and every unmapped address (0x400, 0x424 and up, the 0xC00 region) read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 12 | Byte address within the bank |
| busWrData | input | 8 | Write data |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 8 | Read data, same cycle as busRdEn |
| pinIn | input | 8 | Pin input levels (asynchronous) |
| pinOut | output | 8 | Pin output values |
| pinOe | output | 8 | Pin output enables |
| altOut | input | 8 | Alternate-function output values |
| altOe | input | 8 | Alternate-function output enables |
| irqOut | output | 1 | Combined interrupt request |

## Verification
A corrupted output-value or direction bit reaches `pinOut` or `pinOe` on the clock edge that latches the write, so it is visible one cycle after the bus write. A wrong synchronizer or edge-history bit shows up as a false or missing latched status three edges after the pin changes. It appears both in the raw-status read and, when that pin is enabled, on `irqOut`. A latch that clears without a clear write, or that loses an edge arriving together with a clear, stays wrong until the next matching edge. The checks therefore hold pins stable for several cycles and then compare the status reads against a model of every edge the bench produced.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned PIN_COUNT = 8;
  localparam int unsigned ADDR_W    = PIN_COUNT + 4;
  localparam int unsigned CFG_IDX_W = 4;

  typedef enum logic [3:0] {
    RD_NONE, RD_DATA, RD_DIR, RD_MODE, RD_BOTH, RD_POL,
    RD_ENABLE, RD_RAW, RD_MASKED, RD_ALT
  } rdSel_e;

  typedef struct packed {
    logic   wrData;
    logic   wrDir;
    logic   wrMode;
    logic   wrBoth;
    logic   wrPol;
    logic   wrEnable;
    logic   wrClear;
    logic   wrAlt;
    rdSel_e rdSel;
  } busStrobe_t;

  typedef struct packed {
    logic [PIN_COUNT-1:0] outData;
    logic [PIN_COUNT-1:0] outEn;
    logic [PIN_COUNT-1:0] levelMode;
    logic [PIN_COUNT-1:0] bothEdge;
    logic [PIN_COUNT-1:0] highActive;
    logic [PIN_COUNT-1:0] irqEn;
    logic [PIN_COUNT-1:0] altSel;
  } bankCfg_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  output busStrobe_t           strobe,
  output logic [PIN_COUNT-1:0] pinMask
);
  localparam int unsigned MASK_LSB = 2;
  localparam int unsigned MASK_MSB = PIN_COUNT + 1;
  localparam int unsigned IDX_MSB  = MASK_LSB + CFG_IDX_W - 1;

  logic [1:0]           region;
  logic [CFG_IDX_W-1:0] cfgIdx;
  logic                 cfgHighZero;

  assign region      = busAddr[ADDR_W-1 -: 2];
  assign pinMask     = busAddr[MASK_MSB:MASK_LSB];
  assign cfgIdx      = busAddr[IDX_MSB:MASK_LSB];
  assign cfgHighZero = (busAddr[MASK_MSB:IDX_MSB+1] == '0);

  always_comb begin
    strobe       = '0;
    strobe.rdSel = RD_NONE;
    unique case (region)
      2'b00: begin
        strobe.wrData = busWrEn;
        if (busRdEn) strobe.rdSel = RD_DATA;
      end
      2'b10: begin
        strobe.wrDir = busWrEn;
        if (busRdEn) strobe.rdSel = RD_DIR;
      end
      2'b01: begin
        if (cfgHighZero) begin
          case (cfgIdx)
            4'd1: begin strobe.wrMode   = busWrEn; if (busRdEn) strobe.rdSel = RD_MODE;   end
            4'd2: begin strobe.wrBoth   = busWrEn; if (busRdEn) strobe.rdSel = RD_BOTH;   end
            4'd3: begin strobe.wrPol    = busWrEn; if (busRdEn) strobe.rdSel = RD_POL;    end
            4'd4: begin strobe.wrEnable = busWrEn; if (busRdEn) strobe.rdSel = RD_ENABLE; end
            4'd5: begin if (busRdEn) strobe.rdSel = RD_RAW; end
            4'd6: begin if (busRdEn) strobe.rdSel = RD_MASKED; end
            4'd7: begin strobe.wrClear  = busWrEn; end
            4'd8: begin strobe.wrAlt    = busWrEn; if (busRdEn) strobe.rdSel = RD_ALT;    end
            default: ;
          endcase
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  busStrobe_t           strobe,
  input  logic [PIN_COUNT-1:0] pinMask,
  input  logic [PIN_COUNT-1:0] wrData,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  logic [PIN_COUNT-1:0] altOut,
  input  logic [PIN_COUNT-1:0] altOe,
  output logic [PIN_COUNT-1:0] rdData,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic                 irqOut,
  output bankCfg_t             cfgQ,
  output logic [PIN_COUNT-1:0] rawStat,
  output logic [PIN_COUNT-1:0] syncPin,
  output logic [PIN_COUNT-1:0] prevPin
);
  logic [PIN_COUNT-1:0] clrBits;
  logic [PIN_COUNT-1:0] maskedStat;

  assign clrBits = strobe.wrClear ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else begin
      if (strobe.wrData)   cfgQ.outData    <= (cfgQ.outData & ~pinMask) | (wrData & pinMask);
      if (strobe.wrDir)    cfgQ.outEn      <= (cfgQ.outEn & ~pinMask) | (wrData & pinMask);
      if (strobe.wrMode)   cfgQ.levelMode  <= wrData;
      if (strobe.wrBoth)   cfgQ.bothEdge   <= wrData;
      if (strobe.wrPol)    cfgQ.highActive <= wrData;
      if (strobe.wrEnable) cfgQ.irqEn      <= wrData;
      if (strobe.wrAlt)    cfgQ.altSel     <= wrData;
    end
  end

  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    logic syncA;
    logic syncB;
    logic prevB;
    logic edgeLatch;
    logic edgeHit;

    assign edgeHit = ~cfgQ.levelMode[i] &
                     (cfgQ.bothEdge[i]   ? (syncB ^ prevB) :
                      cfgQ.highActive[i] ? (syncB & ~prevB) : (~syncB & prevB));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA     <= 1'b0;
        syncB     <= 1'b0;
        prevB     <= 1'b0;
        edgeLatch <= 1'b0;
      end else begin
        syncA     <= pinIn[i];
        syncB     <= syncA;
        prevB     <= syncB;
        edgeLatch <= cfgQ.levelMode[i] ? 1'b0 : ((edgeLatch & ~clrBits[i]) | edgeHit);
      end
    end

    assign rawStat[i] = cfgQ.levelMode[i] ? ~(syncB ^ cfgQ.highActive[i]) : edgeLatch;
    assign syncPin[i] = syncB;
    assign prevPin[i] = prevB;
    assign pinOut[i]  = cfgQ.altSel[i] ? altOut[i] : cfgQ.outData[i];
    assign pinOe[i]   = cfgQ.altSel[i] ? altOe[i]  : cfgQ.outEn[i];
  end

  assign maskedStat = rawStat & cfgQ.irqEn;
  assign irqOut     = |maskedStat;

  always_comb begin
    unique case (strobe.rdSel)
      RD_DATA:   rdData = syncPin & pinMask;
      RD_DIR:    rdData = cfgQ.outEn & pinMask;
      RD_MODE:   rdData = cfgQ.levelMode;
      RD_BOTH:   rdData = cfgQ.bothEdge;
      RD_POL:    rdData = cfgQ.highActive;
      RD_ENABLE: rdData = cfgQ.irqEn;
      RD_RAW:    rdData = rawStat;
      RD_MASKED: rdData = maskedStat;
      RD_ALT:    rdData = cfgQ.altSel;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [PIN_COUNT-1:0] busWrData,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  output logic [PIN_COUNT-1:0] busRdData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  input  logic [PIN_COUNT-1:0] altOut,
  input  logic [PIN_COUNT-1:0] altOe,
  output logic                 irqOut
);
  busStrobe_t           strobe;
  logic [PIN_COUNT-1:0] pinMask;
  bankCfg_t             cfgQ;
  logic [PIN_COUNT-1:0] rawStat;
  logic [PIN_COUNT-1:0] syncPin;
  logic [PIN_COUNT-1:0] prevPin;

  gpio_bank_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobe  (strobe),
    .pinMask (pinMask)
  );

  gpio_bank_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .pinMask (pinMask),
    .wrData  (busWrData),
    .pinIn   (pinIn),
    .altOut  (altOut),
    .altOe   (altOe),
    .rdData  (busRdData),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .irqOut  (irqOut),
    .cfgQ    (cfgQ),
    .rawStat (rawStat),
    .syncPin (syncPin),
    .prevPin (prevPin)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [PIN_COUNT-1:0] busWrData,
  input logic                 busWrEn,
  input logic                 irqOut,
  input bankCfg_t             cfgQ,
  input logic [PIN_COUNT-1:0] rawStat,
  input logic [PIN_COUNT-1:0] syncPin,
  input logic [PIN_COUNT-1:0] prevPin
);
  logic                 dataWrite;
  logic                 dirWrite;
  logic [PIN_COUNT-1:0] addrMask;
  logic [PIN_COUNT-1:0] clrReq;

  assign dataWrite = busWrEn && (busAddr[ADDR_W-1 -: 2] == 2'b00);
  assign dirWrite  = busWrEn && (busAddr[ADDR_W-1 -: 2] == 2'b10);
  assign addrMask  = busAddr[PIN_COUNT+1:2];
  assign clrReq    = (busWrEn && busAddr[ADDR_W-1:2] == 10'h107) ? busWrData : '0;

  assert_data_mask_R2: assert property (@(posedge clk) disable iff (!rstN)
    dataWrite |=> (((cfgQ.outData & $past(addrMask)) == ($past(busWrData) & $past(addrMask))) &&
                   ((cfgQ.outData & ~$past(addrMask)) == ($past(cfgQ.outData) & ~$past(addrMask)))));

  assert_dir_mask_R4: assert property (@(posedge clk) disable iff (!rstN)
    dirWrite |=> (((cfgQ.outEn & $past(addrMask)) == ($past(busWrData) & $past(addrMask))) &&
                  ((cfgQ.outEn & ~$past(addrMask)) == ($past(cfgQ.outEn) & ~$past(addrMask)))));

  assert_both_edge_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(~cfgQ.levelMode & cfgQ.bothEdge & (syncPin ^ prevPin)) &
               ~cfgQ.levelMode & ~rawStat) == '0));

  assert_edge_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(rawStat & ~cfgQ.levelMode & ~clrReq) & ~cfgQ.levelMode & ~rawStat) == '0));

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ.irqEn == '0) |-> !irqOut);
endmodule

bind gpio_bank gpio_bank_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .busWrEn   (busWrEn),
  .irqOut    (irqOut),
  .cfgQ      (cfgQ),
  .rawStat   (rawStat),
  .syncPin   (syncPin),
  .prevPin   (prevPin)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busRdData;
  logic [7:0]  pinIn = '0;
  logic [7:0]  pinOut;
  logic [7:0]  pinOe;
  logic [7:0]  altOut = '0;
  logic [7:0]  altOe = '0;
  logic        irqOut;

  int compared = 0;
  int mismatched = 0;

  logic [7:0] mData = '0, mDir = '0, mMode = '0, mBoth = '0, mPol = '0;
  logic [7:0] mEn = '0, mAlt = '0, mLatch = '0, mPins = '0;

  always #2 clk = ~clk;

  gpio_bank dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busRdData(busRdData),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .altOut(altOut), .altOe(altOe), .irqOut(irqOut)
  );

  function automatic logic [7:0] expRaw();
    return (mMode & ~(mPins ^ mPol)) | (~mMode & mLatch);
  endfunction

  function automatic logic [7:0] expRead(logic [11:0] a);
    logic [7:0] m;
    m = a[9:2];
    case (a[11:10])
      2'b00: return mPins & m;
      2'b10: return mDir & m;
      2'b01: begin
        if (a[9:6] != 4'd0) return 8'h00;
        case (a[5:2])
          4'd1: return mMode;
          4'd2: return mBoth;
          4'd3: return mPol;
          4'd4: return mEn;
          4'd5: return expRaw();
          4'd6: return expRaw() & mEn;
          4'd8: return mAlt;
          default: return 8'h00;
        endcase
      end
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [11:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    if (a[11:10] == 2'b00) mData = (mData & ~a[9:2]) | (d & a[9:2]);
    else if (a[11:10] == 2'b10) mDir = (mDir & ~a[9:2]) | (d & a[9:2]);
    else if (a[11:10] == 2'b01 && a[9:6] == 4'd0) begin
      case (a[5:2])
        4'd1: begin mMode = d; mLatch = mLatch & ~d; end
        4'd2: mBoth = d;
        4'd3: mPol = d;
        4'd4: mEn = d;
        4'd7: mLatch = mLatch & ~d;
        4'd8: mAlt = d;
        default: ;
      endcase
    end
  endtask

  task automatic checkRead(string tag, logic [11:0] a);
    logic [7:0] d;
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    busRdEn = 1'b0;
    check(tag, d, expRead(a));
  endtask

  task automatic setPins(logic [7:0] v);
    logic [7:0] hit;
    hit = ~mMode & ((mBoth & (v ^ mPins)) | (~mBoth & mPol & v & ~mPins) |
                    (~mBoth & ~mPol & ~v & mPins));
    mLatch = mLatch | hit;
    @(negedge clk);
    pinIn = v;
    mPins = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic checkPorts(string tag);
    @(negedge clk);
    #1;
    check({tag, " pinOut R5"}, pinOut, (mAlt & altOut) | (~mAlt & mData));
    check({tag, " pinOe R4"}, pinOe, (mAlt & altOe) | (~mAlt & mDir));
    check({tag, " irqOut R9"}, {7'd0, irqOut}, {7'd0, |(expRaw() & mEn)});
  endtask

  initial begin
    #800000;
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pinOe", pinOe, 8'h00);
    check("R1 pinOut", pinOut, 8'h00);
    check("R1 irqOut", {7'd0, irqOut}, 8'h00);
    checkRead("R1 mode reg", 12'h404);

    // R2 masked data write, single pin and group
    busWrite(12'h000 | (12'd4 << 3), 8'hFF);
    checkPorts("R2 single pin");
    busWrite({2'b00, 8'b1010_0000, 2'b00}, 8'h60);
    checkPorts("R2 group");
    // R4 direction masked
    busWrite({2'b10, 8'h0F, 2'b00}, 8'hFF);
    checkPorts("R4 dir");
    checkRead("R4 dir read", {2'b10, 8'h3C, 2'b00});
    // R3 data read after synchronization
    setPins(8'hA5);
    checkRead("R3 masked read", {2'b00, 8'h0F, 2'b00});
    checkRead("R3 full read", {2'b00, 8'hFF, 2'b00});
    // R5 alternate select
    altOut = 8'h3C; altOe = 8'hC3;
    busWrite(12'h420, 8'h0F);
    checkPorts("R5 alt");
    checkRead("R11 alt readback", 12'h420);
    // R6 level mode, active high on pin 0, active low on pin 1
    setPins(8'h00);
    busWrite(12'h404, 8'h03);
    busWrite(12'h40C, 8'h01);
    busWrite(12'h410, 8'h03);
    checkRead("R6 level low pin1", 12'h414);
    setPins(8'h03);
    checkRead("R6 level high pin0", 12'h414);
    // R10 clear has no effect on level bits
    busWrite(12'h41C, 8'hFF);
    checkRead("R10 level unaffected", 12'h414);
    checkPorts("R9 level irq");
    // R7 edge modes: pin2 rising, pin3 falling
    busWrite(12'h404, 8'h00);
    busWrite(12'h40C, 8'h04);
    busWrite(12'h410, 8'h00);
    checkPorts("R9 irq off");
    setPins(8'h04);
    checkRead("R7 rise latched", 12'h414);
    setPins(8'h08);
    checkRead("R7 fall/sticky", 12'h414);
    setPins(8'h00);
    checkRead("R7 fall latched", 12'h414);
    // R8 both edges ignore polarity
    busWrite(12'h41C, 8'hFF);
    busWrite(12'h408, 8'h30);
    setPins(8'h10);
    setPins(8'h30);
    setPins(8'h10);
    checkRead("R8 both edges", 12'h414);
    busWrite(12'h410, 8'h20);
    checkRead("R9 masked", 12'h418);
    checkPorts("R9 edge irq");
    busWrite(12'h41C, 8'h20);
    checkRead("R10 clear", 12'h414);
    checkPorts("R10 irq after clear");
    // R11 write to status ignored, unmapped reads zero
    busWrite(12'h414, 8'hFF);
    checkRead("R11 raw ignores write", 12'h414);
    checkRead("R11 clear reads zero", 12'h41C);
    checkRead("R11 unmapped 400", 12'h400);
    checkRead("R11 unmapped 424", 12'h424);
    checkRead("R11 unmapped C00", 12'hC04);

    // constrained random
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom % 8;
      case (op)
        0: busWrite({2'b00, 8'($urandom), 2'b00}, 8'($urandom));
        1: busWrite({2'b10, 8'($urandom), 2'b00}, 8'($urandom));
        2: begin
          logic [3:0] idx;
          idx = 4'(1 + $urandom % 8);
          busWrite({2'b01, 4'd0, idx, 2'b00}, 8'($urandom));
        end
        3, 4: setPins(8'($urandom));
        5: begin altOut = 8'($urandom); altOe = 8'($urandom); end
        default: ;
      endcase
      if (op >= 5) begin
        logic [3:0] ridx;
        ridx = 4'($urandom % 10);
        checkRead("R9 rand status", {2'b01, 4'd0, ridx, 2'b00});
        checkRead("R3 rand data", {2'b00, 8'($urandom), 2'b00});
        checkPorts("R5 rand");
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule